// File: doc/BRIEF.md
# Walking-halfword memory pattern writer and dual-view checker

The block fills a memory region with a fixed test pattern and later checks that two read views of the region agree. It has two independent engines. The writer produces one word for every 32-bit location of a 4 KB region. Each word goes out on a valid/ready write port together with its byte address. The pattern comes from an 8-bit index that runs 0 to 255. Each index covers four consecutive words, and every bit of the index turns one whole 16-bit halfword to all ones.

The checker takes two ordered data streams over the same region, for example one read through a cache and one read around it. It pairs the words up and compares them. The full region is compared a configurable number of times, two by default. The first unequal pair ends the run at once. A one-cycle result pulse carries the pass/fail bit. The block does no arbitration and no address mapping beyond a base address.

Top module: `mtp_pattern_checker`

## Requirements
- R1: Write word w (0 to 1023) is issued with address BASE_ADDR + 4*w. Words go out in increasing w, which means increasing index and, within one index, increasing word slot k (w = 4*index + k).
- R2: For word slot k of an index, data bits 15:0 are 0xFFFF when index bit 2k is set and zero otherwise. Data bits 31:16 are 0xFFFF when index bit 2k+1 is set and zero otherwise.
- R3: While the write valid is high and ready is low, the write valid, address and data hold their values. The word counter advances only on an accepted transfer.
- R4: The write done output is high for exactly one cycle, in the cycle after the transfer of word 1023 is accepted. No write valid follows it.
- R5: A write start that arrives while a sweep is running has no effect. The sweep still emits exactly 1024 words and one done pulse.
- R6: The checker takes a pair only when both stream valids are high. Both ready outputs are then high together in that cycle. With only one valid high, neither ready is high.
- R7: On the first pair whose two words differ, the result valid goes high with the fail bit set in the next cycle. No further pair is taken after that pair.
- R8: When NUM_PASSES full passes of 1024 equal pairs complete, the result valid goes high with the fail bit clear in the cycle after the last pair. The result valid lasts exactly one cycle.
- R9: After reset, no write valid, no read ready and no result valid are driven.
- R10: A check start that arrives while a check is running has no effect. The running check neither restarts nor shortens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Starts a pattern write sweep when idle |
| wr_valid_o | output | 1 | Write word available |
| wr_ready_i | input | 1 | Memory accepts the write word |
| wr_addr_o | output | ADDR_W | Byte address of the write word |
| wr_data_o | output | 32 | Pattern word |
| wr_done_o | output | 1 | One-cycle pulse after the last word is accepted |
| chk_start_i | input | 1 | Starts a compare run when idle |
| a_valid_i | input | 1 | First read stream word valid |
| a_data_i | input | 32 | First read stream word |
| a_ready_o | output | 1 | First read stream word taken |
| b_valid_i | input | 1 | Second read stream word valid |
| b_data_i | input | 32 | Second read stream word |
| b_ready_o | output | 1 | Second read stream word taken |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_fail_o | output | 1 | Result of the last run, 1 on mismatch |

## Verification
The hardest situations to reach are the pass boundaries of the compare run. One is a mismatch on the very last word of the first pass, which must end the run before a second pass begins. Another is a full pass that must wrap cleanly into the next. The bench feeds both streams from a word counter that runs across the passes. It injects the corruption at a chosen global pair number, including pair 1023 and pair 1029. The two stream valids are gated by independent pseudo-random bits, so the bench can confirm that one-sided valids never produce a ready.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned DATA_W    = 2 * HALF_W;
  localparam int unsigned WPI       = IDX_W / 2;          // words per index
  localparam int unsigned K_W       = $clog2(WPI);
  localparam int unsigned WORD_W    = IDX_W + K_W;
  localparam int unsigned NUM_WORDS = 1 << WORD_W;

  function automatic logic [DATA_W-1:0] pat_word(input logic [WORD_W-1:0] w);
    logic [IDX_W-1:0]  idx;
    int unsigned       kk;
    logic [DATA_W-1:0] d;
    idx = w[WORD_W-1:K_W];
    kk  = int'(w[K_W-1:0]);
    d   = '0;
    if (idx[2*kk])   d[HALF_W-1:0]      = '1;
    if (idx[2*kk+1]) d[DATA_W-1:HALF_W] = '1;
    return d;
  endfunction
endpackage

// File: rtl/mtp_pattern_gen.sv
module mtp_pattern_gen
  import mtp_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic              busy_q, done_q;
  logic [WORD_W-1:0] word_q;
  logic              last_w;

  assign last_w  = (word_q == WORD_W'(NUM_WORDS - 1));
  assign valid_o = busy_q;
  assign addr_o  = BASE_ADDR + (ADDR_W'(word_q) << 2);
  assign data_o  = pat_word(word_q);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          word_q <= '0;
        end
      end else if (ready_i) begin
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

  a_r3_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o));
  a_r1_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_w |=> addr_o == $past(addr_o) + ADDR_W'(4));
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !valid_o);
endmodule

// File: rtl/mtp_stream_cmp.sv
module mtp_stream_cmp
  import mtp_pkg::*;
#(
  parameter int unsigned NUM_PASSES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              a_ready_o,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              b_ready_o,
  output logic              res_valid_o,
  output logic              res_fail_o
);
  localparam int unsigned PASS_W = (NUM_PASSES > 1) ? $clog2(NUM_PASSES) : 1;

  logic              busy_q, res_valid_q, res_fail_q;
  logic [WORD_W-1:0] word_q;
  logic [PASS_W-1:0] pass_q;
  logic              take;

  assign take        = busy_q && a_valid_i && b_valid_i;
  assign a_ready_o   = take;
  assign b_ready_o   = take;
  assign res_valid_o = res_valid_q;
  assign res_fail_o  = res_fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      res_valid_q <= 1'b0;
      res_fail_q  <= 1'b0;
      word_q      <= '0;
      pass_q      <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          word_q <= '0;
          pass_q <= '0;
        end
      end else if (take) begin
        if (a_data_i != b_data_i) begin
          busy_q      <= 1'b0;
          res_valid_q <= 1'b1;
          res_fail_q  <= 1'b1;
        end else if (word_q == WORD_W'(NUM_WORDS - 1)) begin
          word_q <= '0;
          if (pass_q == PASS_W'(NUM_PASSES - 1)) begin
            busy_q      <= 1'b0;
            res_valid_q <= 1'b1;
            res_fail_q  <= 1'b0;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

  a_r7_fail_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_fail_o |-> $past(a_ready_o && (a_data_i != b_data_i)));
  a_r8_pass_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_fail_o |-> $past(a_ready_o && (a_data_i == b_data_i)));
  a_r7_stop_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !a_ready_o && !b_ready_o);
  a_r8_res_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

// File: rtl/mtp_pattern_checker.sv
module mtp_pattern_checker
  import mtp_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h2000,
  parameter int unsigned       NUM_PASSES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              wr_done_o,
  input  logic              chk_start_i,
  input  logic              a_valid_i,
  input  logic [31:0]       a_data_i,
  output logic              a_ready_o,
  input  logic              b_valid_i,
  input  logic [31:0]       b_data_i,
  output logic              b_ready_o,
  output logic              res_valid_o,
  output logic              res_fail_o
);
  mtp_pattern_gen #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_start_i),
    .valid_o (wr_valid_o),
    .ready_i (wr_ready_i),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o),
    .done_o  (wr_done_o)
  );

  mtp_stream_cmp #(.NUM_PASSES(NUM_PASSES)) i_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (chk_start_i),
    .a_valid_i   (a_valid_i),
    .a_data_i    (a_data_i),
    .a_ready_o   (a_ready_o),
    .b_valid_i   (b_valid_i),
    .b_data_i    (b_data_i),
    .b_ready_o   (b_ready_o),
    .res_valid_o (res_valid_o),
    .res_fail_o  (res_fail_o)
  );

  a_r6_join: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_ready_o || b_ready_o) |-> a_valid_i && b_valid_i && a_ready_o && b_ready_o);
endmodule

// File: tb/test_mtp_pattern_checker.sv
module test_mtp_pattern_checker;
  localparam logic [31:0] BASE = 32'h2000;
  localparam int NW = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 1'b0, wr_valid, wr_ready = 1'b0, wr_done;
  logic [31:0] wr_addr, wr_data;
  logic chk_start = 1'b0, a_valid = 1'b0, b_valid = 1'b0, a_ready, b_ready;
  logic [31:0] a_data = '0, b_data = '0;
  logic res_valid, res_fail;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  int done_cnt = 0;
  bit wr_mon_on = 1'b0;

  always #5 clk = ~clk;

  mtp_pattern_checker i_mtp_pattern_checker (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_start_i(wr_start), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_done_o(wr_done),
    .chk_start_i(chk_start),
    .a_valid_i(a_valid), .a_data_i(a_data), .a_ready_o(a_ready),
    .b_valid_i(b_valid), .b_data_i(b_data), .b_ready_o(b_ready),
    .res_valid_o(res_valid), .res_fail_o(res_fail)
  );

  function automatic logic [31:0] exp_word(int w);
    int idx = w / 4;
    int k = w % 4;
    logic [31:0] d = '0;
    if (((idx >> (2 * k)) & 1) == 1)     d[15:0]  = 16'hFFFF;
    if (((idx >> (2 * k + 1)) & 1) == 1) d[31:16] = 16'hFFFF;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write monitor: drives ready, pops scoreboard on each accepted word
  logic [15:0] wlfsr = 16'hACE1;
  bit stall_prev = 1'b0;
  logic [31:0] prev_addr, prev_data;
  always begin
    @(negedge clk);
    if (wr_mon_on) begin
      if (wr_done) begin
        done_cnt++;
        chk(exp_q.size() == 0, "R4", "done with words pending", 64'(exp_q.size()), 64'd0);
      end
      wlfsr = {wlfsr[14:0], wlfsr[15] ^ wlfsr[13] ^ wlfsr[12] ^ wlfsr[10]};
      wr_ready = wlfsr[0] | wlfsr[4];
      #1;
      if (stall_prev)
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R3",
            "held word", {wr_addr, wr_data}, {prev_addr, prev_data});
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "extra write word", {wr_addr, wr_data}, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(wr_addr == e[63:32], "R1", "address", 64'(wr_addr), 64'(e[63:32]));
          chk(wr_data == e[31:0], "R2", "data", 64'(wr_data), 64'(e[31:0]));
        end
      end
      stall_prev = wr_valid && !wr_ready;
      prev_addr = wr_addr;
      prev_data = wr_data;
    end
  end

  task automatic do_write();
    for (int w = 0; w < NW; w++) exp_q.push_back({BASE + 32'(4 * w), exp_word(w)});
    wr_mon_on = 1'b1;
    @(negedge clk); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
    repeat (300) @(negedge clk);
    wr_start = 1'b1;                       // R5: start while busy
    @(negedge clk); wr_start = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R4", "done pulse count", 64'(done_cnt), 64'd1);
    chk(exp_q.size() == 0, "R5", "words left after sweep", 64'(exp_q.size()), 64'd0);
    chk(!wr_valid, "R4", "valid after done", 64'(wr_valid), 64'd0);
    wr_mon_on = 1'b0;
  endtask

  logic [15:0] clfsr = 16'h1D2B;
  task automatic run_cmp(input int mis, input bit poke, input string req);
    int p = 0;
    int viol = 0;
    bit seen = 1'b0;
    @(negedge clk); chk_start = 1'b1;
    @(negedge clk); chk_start = 1'b0;
    for (int it = 0; it < 20000; it++) begin
      if (it > 0) @(negedge clk);
      if (res_valid) begin seen = 1'b1; break; end
      clfsr = {clfsr[14:0], clfsr[15] ^ clfsr[13] ^ clfsr[12] ^ clfsr[10]};
      a_valid = clfsr[0] | clfsr[3];
      b_valid = clfsr[1] | clfsr[6];
      a_data = exp_word(p % NW);
      b_data = (p == mis) ? (exp_word(p % NW) ^ 32'h0001_0000) : exp_word(p % NW);
      chk_start = poke && (it == 200);     // R10: start while running
      #1;
      if ((a_ready != (a_valid && b_valid)) || (b_ready != a_ready)) viol++;
      if (a_ready) p++;
    end
    chk_start = 1'b0;
    chk(seen, req, "result pulse seen", 64'(seen), 64'd1);
    chk(viol == 0, "R6", "ready without both valids", 64'(viol), 64'd0);
    if (mis < 0) begin
      chk(p == 2 * NW, "R8", "pairs before pass", 64'(p), 64'(2 * NW));
      chk(!res_fail, "R8", "fail bit on equal data", 64'(res_fail), 64'd0);
    end else begin
      chk(p == mis + 1, "R7", "pairs before fail", 64'(p), 64'(mis + 1));
      chk(res_fail, "R7", "fail bit on mismatch", 64'(res_fail), 64'd1);
    end
    a_valid = 1'b1; b_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      if (i == 0) chk(!res_valid, "R8", "result pulse width", 64'(res_valid), 64'd0);
      chk(!a_ready && !b_ready, "R7", "ready after result", {a_ready, b_ready}, 64'd0);
    end
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    a_valid = 1'b1; b_valid = 1'b1; #1;
    chk(!wr_valid, "R9", "write valid in reset", 64'(wr_valid), 64'd0);
    chk(!a_ready && !b_ready, "R9", "ready in reset", {a_ready, b_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!wr_valid, "R9", "write valid after reset", 64'(wr_valid), 64'd0);
    chk(!a_ready && !b_ready, "R9", "ready when idle", {a_ready, b_ready}, 64'd0);
    chk(!res_valid, "R9", "result after reset", 64'(res_valid), 64'd0);
    a_valid = 1'b0; b_valid = 1'b0;

    do_write();
    run_cmp(-1, 1'b1, "R10");          // full pass run with a start poke
    run_cmp(NW + 5, 1'b0, "R7");       // mismatch in second pass
    run_cmp(NW - 1, 1'b0, "R7");       // mismatch on last word of first pass
    run_cmp(0, 1'b0, "R7");            // mismatch on first pair
    run_cmp(-1, 1'b0, "R8");           // clean run

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule